// File: doc/BRIEF.md
# Unified Interconnect Boot Sequencer

This block brings up a reconfigurable device in which a single on-chip network carries three kinds of traffic: configuration bitstreams, programming of the network interfaces, and functional data. After reset it steps through a fixed series of phases. First it waits out its own configuration time. It then writes the network connection registers through a memory-mapped master port, and streams a bitstream from external memory to the configuration port of a soft region. Next it rewires the network and writes the control registers of the now-configured IP. Last, it hands the device over to application mode.

Two reset outputs are sequenced separately. The network leaves reset once the sequencer's own setup is over. The soft IP is held in reset until its bitstream has been delivered. All register writes come from a built-in table of address/data pairs, issued one at a time. An error response ends the boot in a sticky error phase.

Top module: `boot_seq_top`

## Requirements
- R1: The `phase` output moves only forward through 0 (self setup), 1 (network programming), 2 (bitstream load), 3 (IP programming) and 4 (application), or jumps to 7 (error). Phases 4 and 7 are final until reset.
- R2: `noc_rst_n` stays low in phase 0 and goes high on entering phase 1. Phase 0 lasts SELF_CYCLES+2 clock cycles after `rst_n` rises, two of which are reset synchronisation. The IP reset `ip_rst_n` stays low through phases 0, 1 and 2.
- R3: `ip_rst_n` rises on entering phase 3 and stays high in phase 4. The IP is therefore out of reset for every phase-3 write.
- R4: In phase 1 the block writes N_NET entries, k = 0..N_NET-1, in order. Entry k has address NI_BASE + 4k and data 0xC1000000 + k.
- R5: In phase 3 the block first rewrites N_RECON connection entries, with address NI_BASE + 4k and data 0xC2000000 + k. It then writes N_IPW IP registers, with address IP_BASE + 4k and data 0xA1000000 + k. Both groups run in order of k.
- R6: At most one write is outstanding. A new request is raised only after the response to the previous one. A request held without `mm_req_ready` keeps its address and data.
- R7: In phase 2 the block reads words from `bs_base` up to `bs_base + bs_count - 1` in increasing order. It sends each returned word exactly once, in order, on `cfg_data`.
- R8: While `cfg_valid` is high and `cfg_ready` is low, `cfg_valid` stays high and `cfg_data` is unchanged.
- R9: With `bs_count` = 0, no word is read or sent, and the sequence moves on to phase 3.
- R10: A response with `mm_rsp_err` high ends the boot in phase 7. No further write is issued. `ip_rst_n` is low in that phase, and later responses have no effect.
- R11: `mm_req_valid` is high only in phases 1 and 3. `mem_req_valid` and `cfg_valid` are high only in phase 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bs_base | input | MAW | First bitstream word address |
| bs_count | input | CW | Number of bitstream words |
| mm_req_valid | output | 1 | Write request valid |
| mm_req_ready | input | 1 | Write request accepted |
| mm_req_addr | output | AW | Write address |
| mm_req_data | output | DW | Write data |
| mm_rsp_valid | input | 1 | Write response valid |
| mm_rsp_err | input | 1 | Write response carries an error |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | MAW | Memory read word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DW | Read data |
| cfg_valid | output | 1 | Configuration word valid |
| cfg_ready | input | 1 | Configuration port accepts word |
| cfg_data | output | DW | Configuration word |
| noc_rst_n | output | 1 | Network reset, active low |
| ip_rst_n | output | 1 | Soft IP reset, active low |
| phase | output | 3 | Current phase code |

## Verification
Complete boots are run with several patterns on the configuration port:
- always ready, which checks word order and count;
- ready one cycle in three, and ready one cycle in eight, which show whether a word is dropped or repeated under backpressure.

The memory and write ports are also run both always ready and toggling. Either way the table writes must still come out in order, with only one outstanding. One run uses a bitstream that crosses a 4 KiB address boundary. Another uses a zero word count, which shows that the load phase does not hang. Error responses are injected on a network write and on an IP write. These show whether the error is sticky, whether writing stops, and whether the IP reset is pulled back low after it was released.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [2:0] {
    PH_SELF = 3'd0,
    PH_NET  = 3'd1,
    PH_CFG  = 3'd2,
    PH_IPP  = 3'd3,
    PH_APP  = 3'd4,
    PH_ERR  = 3'd7
  } phase_e;
endpackage

// File: rtl/boot_seq_wtable.sv
module boot_seq_wtable #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int N_NET = 3,
  parameter int N_RECON = 2,
  parameter int N_IPW = 3,
  parameter logic [AW-1:0] NI_BASE = 16'h1000,
  parameter logic [AW-1:0] IP_BASE = 16'h4000,
  parameter int N_TOT = N_NET + N_RECON + N_IPW,
  parameter int IW = $clog2(N_TOT)
) (
  input  logic [IW-1:0] idx,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  logic [AW-1:0] ent_addr [N_TOT];
  logic [DW-1:0] ent_data [N_TOT];

  // one entry per table row: segment 0 network setup, 1 rewiring, 2 IP registers
  for (genvar g = 0; g < N_TOT; g++) begin : g_ent
    localparam int SEG = (g < N_NET) ? 0 : ((g < N_NET + N_RECON) ? 1 : 2);
    localparam int K = (SEG == 0) ? g : ((SEG == 1) ? g - N_NET : g - N_NET - N_RECON);
    localparam logic [AW-1:0] BASE = (SEG == 2) ? IP_BASE : NI_BASE;
    localparam logic [7:0] TAG = (SEG == 0) ? 8'hC1 : ((SEG == 1) ? 8'hC2 : 8'hA1);
    assign ent_addr[g] = BASE + AW'(4 * K);
    assign ent_data[g] = {TAG, {(DW-16){1'b0}}, 8'(K)};
  end

  always_comb begin
    addr = '0;
    data = '0;
    for (int i = 0; i < N_TOT; i++) begin
      if (idx == IW'(i)) begin
        addr = ent_addr[i];
        data = ent_data[i];
      end
    end
  end
endmodule

// File: rtl/boot_seq_mmio_wr.sv
module boot_seq_mmio_wr #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] first_idx,
  input  logic [IW-1:0] last_idx,
  output logic [IW-1:0] idx,
  input  logic [AW-1:0] tbl_addr,
  input  logic [DW-1:0] tbl_data,
  output logic          mm_req_valid,
  input  logic          mm_req_ready,
  output logic [AW-1:0] mm_req_addr,
  output logic [DW-1:0] mm_req_data,
  input  logic          mm_rsp_valid,
  input  logic          mm_rsp_err,
  output logic          done,
  output logic          err
);
  typedef enum logic [1:0] {W_IDLE, W_ISSUE, W_WAIT} wst_e;

  wst_e          st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          idx_en;
  logic          done_q, done_d, err_q, err_d;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    idx_en = 1'b0;
    done_d = 1'b0;
    err_d  = 1'b0;
    case (st_q)
      W_IDLE: begin
        if (start) begin
          idx_d  = first_idx;
          idx_en = 1'b1;
          st_d   = W_ISSUE;
        end
      end
      W_ISSUE: begin
        if (mm_req_ready) st_d = W_WAIT;
      end
      W_WAIT: begin
        if (mm_rsp_valid) begin
          if (mm_rsp_err) begin
            err_d = 1'b1;
            st_d  = W_IDLE;
          end else if (idx_q == last_idx) begin
            done_d = 1'b1;
            st_d   = W_IDLE;
          end else begin
            idx_d  = idx_q + 1'b1;
            idx_en = 1'b1;
            st_d   = W_ISSUE;
          end
        end
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign idx          = idx_q;
  assign mm_req_valid = (st_q == W_ISSUE);
  assign mm_req_addr  = tbl_addr;
  assign mm_req_data  = tbl_data;
  assign done         = done_q;
  assign err          = err_q;
endmodule

// File: rtl/boot_seq_stream.sv
module boot_seq_stream #(
  parameter int MAW = 16,
  parameter int DW = 32,
  parameter int CW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [MAW-1:0] base,
  input  logic [CW-1:0]  count,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [MAW-1:0] mem_req_addr,
  input  logic           mem_rsp_valid,
  input  logic [DW-1:0]  mem_rsp_data,
  output logic           cfg_valid,
  input  logic           cfg_ready,
  output logic [DW-1:0]  cfg_data,
  output logic           done
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_SEND} sst_e;

  sst_e           st_q, st_d;
  logic [MAW-1:0] addr_q, addr_d;
  logic [CW-1:0]  left_q, left_d;
  logic           ptr_en;
  logic [DW-1:0]  word_q;
  logic           word_en;
  logic           done_q, done_d;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    left_d  = left_q;
    ptr_en  = 1'b0;
    word_en = 1'b0;
    done_d  = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          addr_d = base;
          left_d = count;
          ptr_en = 1'b1;
          if (count == '0) done_d = 1'b1;
          else             st_d   = S_REQ;
        end
      end
      S_REQ: begin
        if (mem_req_ready) st_d = S_WAIT;
      end
      S_WAIT: begin
        if (mem_rsp_valid) begin
          word_en = 1'b1;
          st_d    = S_SEND;
        end
      end
      S_SEND: begin
        if (cfg_ready) begin
          addr_d = addr_q + 1'b1;
          left_d = left_q - 1'b1;
          ptr_en = 1'b1;
          if (left_q == CW'(1)) begin
            done_d = 1'b1;
            st_d   = S_IDLE;
          end else begin
            st_d = S_REQ;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      left_q <= '0;
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (ptr_en) begin
        addr_q <= addr_d;
        left_q <= left_d;
      end
      if (word_en) word_q <= mem_rsp_data;
    end
  end

  assign mem_req_valid = (st_q == S_REQ);
  assign mem_req_addr  = addr_q;
  assign cfg_valid     = (st_q == S_SEND);
  assign cfg_data      = word_q;
  assign done          = done_q;
endmodule

// File: rtl/boot_seq_phase_ctrl.sv
module boot_seq_phase_ctrl
  import boot_seq_pkg::*;
#(
  parameter int SELF_CYCLES = 8,
  parameter int N_NET = 3,
  parameter int N_TOT = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_done,
  input  logic          wr_err,
  input  logic          bs_done,
  output phase_e        phase,
  output logic          wr_start,
  output logic [IW-1:0] wr_first,
  output logic [IW-1:0] wr_last,
  output logic          bs_start,
  output logic          noc_rst_n,
  output logic          ip_rst_n
);
  localparam int SCW = $clog2(SELF_CYCLES + 1);

  phase_e         ph_q, ph_d;
  logic [SCW-1:0] cnt_q, cnt_d;
  logic           cnt_en;
  logic           wr_go, bs_go;
  logic           wr_start_q, bs_start_q;
  logic           noc_q, ip_q;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    wr_go  = 1'b0;
    bs_go  = 1'b0;
    case (ph_q)
      PH_SELF: begin
        if (cnt_q == SCW'(SELF_CYCLES - 1)) begin
          ph_d  = PH_NET;
          wr_go = 1'b1;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      PH_NET: begin
        if (wr_err) ph_d = PH_ERR;
        else if (wr_done) begin
          ph_d  = PH_CFG;
          bs_go = 1'b1;
        end
      end
      PH_CFG: begin
        if (bs_done) begin
          ph_d  = PH_IPP;
          wr_go = 1'b1;
        end
      end
      PH_IPP: begin
        if (wr_err)       ph_d = PH_ERR;
        else if (wr_done) ph_d = PH_APP;
      end
      default: ph_d = ph_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_SELF;
      cnt_q      <= '0;
      wr_start_q <= 1'b0;
      bs_start_q <= 1'b0;
      noc_q      <= 1'b0;
      ip_q       <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      wr_start_q <= wr_go;
      bs_start_q <= bs_go;
      noc_q      <= (ph_d != PH_SELF);
      ip_q       <= (ph_d == PH_IPP) || (ph_d == PH_APP);
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign phase     = ph_q;
  assign wr_start  = wr_start_q;
  assign bs_start  = bs_start_q;
  assign wr_first  = (ph_q == PH_IPP) ? IW'(N_NET) : '0;
  assign wr_last   = (ph_q == PH_IPP) ? IW'(N_TOT - 1) : IW'(N_NET - 1);
  assign noc_rst_n = noc_q;
  assign ip_rst_n  = ip_q;
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int MAW = 16,
  parameter int CW = 12,
  parameter int SELF_CYCLES = 8,
  parameter int N_NET = 3,
  parameter int N_RECON = 2,
  parameter int N_IPW = 3,
  parameter logic [AW-1:0] NI_BASE = 16'h1000,
  parameter logic [AW-1:0] IP_BASE = 16'h4000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [MAW-1:0] bs_base,
  input  logic [CW-1:0]  bs_count,
  output logic           mm_req_valid,
  input  logic           mm_req_ready,
  output logic [AW-1:0]  mm_req_addr,
  output logic [DW-1:0]  mm_req_data,
  input  logic           mm_rsp_valid,
  input  logic           mm_rsp_err,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [MAW-1:0] mem_req_addr,
  input  logic           mem_rsp_valid,
  input  logic [DW-1:0]  mem_rsp_data,
  output logic           cfg_valid,
  input  logic           cfg_ready,
  output logic [DW-1:0]  cfg_data,
  output logic           noc_rst_n,
  output logic           ip_rst_n,
  output logic [2:0]     phase
);
  localparam int N_TOT = N_NET + N_RECON + N_IPW;
  localparam int IW = (N_TOT > 1) ? $clog2(N_TOT) : 1;

  logic          rs1_q, rs2_q, rst_i_n;
  phase_e        ph;
  logic          wr_start, wr_done, wr_err, bs_start, bs_done;
  logic [IW-1:0] wr_first, wr_last, wr_idx;
  logic [AW-1:0] tbl_addr;
  logic [DW-1:0] tbl_data;

  // reset asserted at once, released two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i_n = rs2_q;

  boot_seq_phase_ctrl #(
    .SELF_CYCLES(SELF_CYCLES), .N_NET(N_NET), .N_TOT(N_TOT), .IW(IW)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_i_n),
    .wr_done(wr_done), .wr_err(wr_err), .bs_done(bs_done),
    .phase(ph), .wr_start(wr_start), .wr_first(wr_first), .wr_last(wr_last),
    .bs_start(bs_start), .noc_rst_n(noc_rst_n), .ip_rst_n(ip_rst_n)
  );

  boot_seq_wtable #(
    .AW(AW), .DW(DW), .N_NET(N_NET), .N_RECON(N_RECON), .N_IPW(N_IPW),
    .NI_BASE(NI_BASE), .IP_BASE(IP_BASE), .N_TOT(N_TOT), .IW(IW)
  ) tbl_i (
    .idx(wr_idx), .addr(tbl_addr), .data(tbl_data)
  );

  boot_seq_mmio_wr #(.AW(AW), .DW(DW), .IW(IW)) wr_i (
    .clk(clk), .rst_n(rst_i_n),
    .start(wr_start), .first_idx(wr_first), .last_idx(wr_last), .idx(wr_idx),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .mm_req_valid(mm_req_valid), .mm_req_ready(mm_req_ready),
    .mm_req_addr(mm_req_addr), .mm_req_data(mm_req_data),
    .mm_rsp_valid(mm_rsp_valid), .mm_rsp_err(mm_rsp_err),
    .done(wr_done), .err(wr_err)
  );

  boot_seq_stream #(.MAW(MAW), .DW(DW), .CW(CW)) bs_i (
    .clk(clk), .rst_n(rst_i_n),
    .start(bs_start), .base(bs_base), .count(bs_count),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
    .done(bs_done)
  );

  assign phase = ph;
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int MAW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mm_req_valid,
  input logic           mm_req_ready,
  input logic [AW-1:0]  mm_req_addr,
  input logic [DW-1:0]  mm_req_data,
  input logic           mm_rsp_valid,
  input logic           mem_req_valid,
  input logic           mem_req_ready,
  input logic [MAW-1:0] mem_req_addr,
  input logic           cfg_valid,
  input logic           cfg_ready,
  input logic [DW-1:0]  cfg_data,
  input logic           noc_rst_n,
  input logic           ip_rst_n,
  input logic [2:0]     phase
);
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else if (mm_req_valid && mm_req_ready) out_q <= 1'b1;
    else if (mm_rsp_valid) out_q <= 1'b0;
  end

  assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |-> ((phase == $past(phase) + 3'd1) || (phase == 3'd7)));

  assert_noc_before_ip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ip_rst_n |-> noc_rst_n);

  assert_ip_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ip_rst_n) |-> (phase == 3'd3));

  assert_ip_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase <= 3'd2 || phase == 3'd7) |-> !ip_rst_n);

  assert_single_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mm_req_valid |-> !out_q);

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_req_valid && !mm_req_ready) |=>
      (mm_req_valid && $stable(mm_req_addr) && $stable(mm_req_data)));

  assert_mem_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_data)));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd7) |=> (phase == 3'd7));

  assert_mm_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mm_req_valid |-> (phase == 3'd1 || phase == 3'd3));

  assert_stream_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || cfg_valid) |-> (phase == 3'd2));
endmodule

bind boot_seq_top boot_seq_chk #(.AW(AW), .DW(DW), .MAW(MAW)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .mm_req_valid(mm_req_valid), .mm_req_ready(mm_req_ready),
  .mm_req_addr(mm_req_addr), .mm_req_data(mm_req_data),
  .mm_rsp_valid(mm_rsp_valid),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr),
  .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
  .noc_rst_n(noc_rst_n), .ip_rst_n(ip_rst_n), .phase(phase)
);

// File: tb/boot_seq_top_tb_top.sv
`timescale 1ns/1ps
module boot_seq_top_tb_top;
  localparam int SELF_CYCLES = 8;
  localparam int N_NET = 3, N_RECON = 2, N_IPW = 3;
  localparam int N_TOT = N_NET + N_RECON + N_IPW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bs_base = '0;
  logic [11:0] bs_count = '0;
  logic        mm_req_valid, mm_req_ready = 1'b0;
  logic [15:0] mm_req_addr;
  logic [31:0] mm_req_data;
  logic        mm_rsp_valid = 1'b0, mm_rsp_err = 1'b0;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        cfg_valid, cfg_ready = 1'b0;
  logic [31:0] cfg_data;
  logic        noc_rst_n, ip_rst_n;
  logic [2:0]  phase;

  always #10 clk = ~clk;

  boot_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .bs_base(bs_base), .bs_count(bs_count),
    .mm_req_valid(mm_req_valid), .mm_req_ready(mm_req_ready),
    .mm_req_addr(mm_req_addr), .mm_req_data(mm_req_data),
    .mm_rsp_valid(mm_rsp_valid), .mm_rsp_err(mm_rsp_err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
    .noc_rst_n(noc_rst_n), .ip_rst_n(ip_rst_n), .phase(phase)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  // scenario controls, written only by the stimulus
  int mm_mode = 0, mem_mode = 0, cfg_mode = 0, err_at = -1;
  int stray_req = 0;

  // monitor state, written only by the posedge monitor
  logic [15:0] wr_addr [32];
  logic [31:0] wr_data [32];
  logic [2:0]  wr_ph   [32];
  logic        wr_ip   [32];
  logic        wr_noc  [32];
  int          nwr, acc_cnt;
  logic [31:0] cw [64];
  int          ncw, cw_bad;
  logic [2:0]  ph_log [16];
  int          nph;
  logic [2:0]  last_ph;
  int          self_cnt, viol_out, viol_hold, viol_idle;
  logic        mm_out, hold_prev;
  logic [31:0] prev_data;
  int          mem_acc;
  logic [15:0] mem_a_l;

  // responder state, written only by the negedge driver
  int rsp_wait = 0, acc_seen = 0, mem_wait = 0, mem_seen = 0, stray_done = 0;

  function automatic logic [31:0] memf(input logic [15:0] a);
    return {a, ~a};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      nwr = 0; acc_cnt = 0; ncw = 0; cw_bad = 0; nph = 1; ph_log[0] = 3'd0;
      last_ph = 3'd0; self_cnt = 0; viol_out = 0; viol_hold = 0; viol_idle = 0;
      mm_out = 1'b0; hold_prev = 1'b0; prev_data = '0; mem_acc = 0; mem_a_l = '0;
    end else begin
      if (phase == 3'd0) self_cnt++;
      if (phase != last_ph) begin
        if (nph < 16) ph_log[nph] = phase;
        nph++;
        last_ph = phase;
      end
      if (mm_rsp_valid) mm_out = 1'b0;
      if (mm_req_valid && mm_req_ready) begin
        if (mm_out) viol_out++;
        mm_out = 1'b1;
        if (nwr < 32) begin
          wr_addr[nwr] = mm_req_addr; wr_data[nwr] = mm_req_data;
          wr_ph[nwr] = phase; wr_ip[nwr] = ip_rst_n; wr_noc[nwr] = noc_rst_n;
        end
        nwr++;
        acc_cnt++;
      end
      if (mem_req_valid && mem_req_ready) begin
        mem_a_l = mem_req_addr;
        mem_acc++;
      end
      if (hold_prev && !(cfg_valid && cfg_data == prev_data)) viol_hold++;
      hold_prev = cfg_valid && !cfg_ready;
      prev_data = cfg_data;
      if (cfg_valid && cfg_ready) begin
        if (ncw < 64) cw[ncw] = cfg_data;
        ncw++;
        if (!(phase == 3'd2 && !ip_rst_n)) cw_bad++;
      end
      if (mm_req_valid && !(phase == 3'd1 || phase == 3'd3)) viol_idle++;
      if ((mem_req_valid || cfg_valid) && phase != 3'd2) viol_idle++;
    end
  end

  always @(negedge clk) begin
    mm_rsp_valid = 1'b0;
    mm_rsp_err   = 1'b0;
    mem_rsp_valid = 1'b0;
    if (!rst_n) begin
      rsp_wait = 0; acc_seen = 0; mem_wait = 0; mem_seen = 0;
    end else begin
      if (acc_cnt != acc_seen) begin
        acc_seen = acc_cnt;
        rsp_wait = 1 + (acc_cnt % 2);
      end
      if (rsp_wait > 0) begin
        rsp_wait--;
        if (rsp_wait == 0) begin
          mm_rsp_valid = 1'b1;
          mm_rsp_err   = (err_at == acc_seen - 1);
        end
      end
      if (mem_acc != mem_seen) begin
        mem_seen = mem_acc;
        mem_wait = (mem_mode == 0) ? 1 : 3;
      end
      if (mem_wait > 0) begin
        mem_wait--;
        if (mem_wait == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = memf(mem_a_l);
        end
      end
    end
    if (stray_req != stray_done) begin
      stray_done   = stray_req;
      mm_rsp_valid = 1'b1;
    end
    mm_req_ready  = (mm_mode == 0) ? 1'b1 : cyc[0];
    mem_req_ready = (mem_mode == 0) ? 1'b1 : !cyc[0];
    cfg_ready     = (cfg_mode == 0) ? 1'b1 :
                    (cfg_mode == 1) ? (cyc % 3 == 0) : (cyc % 8 == 7);
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_phase(input logic [2:0] p, input int maxc);
    for (int i = 0; i < maxc && phase != p; i++) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(phase == 3'd0, "R1", "phase after reset", phase, 0);
    check(!noc_rst_n && !ip_rst_n, "R2", "resets held after reset", {noc_rst_n, ip_rst_n}, 0);
    check(!mm_req_valid && !mem_req_valid && !cfg_valid, "R11", "ports idle after reset",
          {mm_req_valid, mem_req_valid, cfg_valid}, 0);
  endtask

  task automatic t_boot(input string nm, input logic [15:0] base, input int cnt,
                        input int mmm, input int memm, input int cfgm);
    int bad4, bad5, badph, badip, badnoc, badw;
    mm_mode = mmm; mem_mode = memm; cfg_mode = cfgm; err_at = -1;
    bs_base = base; bs_count = 12'(cnt);
    do_reset();
    wait_phase(3'd4, 20000);
    @(negedge clk);
    check(phase == 3'd4, "R1", {nm, " reached application"}, phase, 4);
    check(nph == 5 && ph_log[1] == 3'd1 && ph_log[2] == 3'd2 && ph_log[3] == 3'd3 &&
          ph_log[4] == 3'd4, "R1", {nm, " phase order"}, nph, 5);
    check(self_cnt == SELF_CYCLES + 2, "R2", {nm, " self setup length"}, self_cnt, SELF_CYCLES + 2);
    check(nwr == N_TOT, "R4", {nm, " write count"}, nwr, N_TOT);
    bad4 = 0; bad5 = 0; badph = 0; badip = 0; badnoc = 0;
    for (int k = 0; k < N_TOT && k < nwr; k++) begin
      logic [15:0] ea; logic [31:0] ed; logic [2:0] ep;
      if (k < N_NET) begin
        ea = 16'h1000 + 16'(4*k); ed = 32'hC100_0000 + k; ep = 3'd1;
      end else if (k < N_NET + N_RECON) begin
        ea = 16'h1000 + 16'(4*(k-N_NET)); ed = 32'hC200_0000 + (k-N_NET); ep = 3'd3;
      end else begin
        ea = 16'h4000 + 16'(4*(k-N_NET-N_RECON)); ed = 32'hA100_0000 + (k-N_NET-N_RECON); ep = 3'd3;
      end
      if (wr_addr[k] != ea || wr_data[k] != ed) begin
        if (k < N_NET) bad4++; else bad5++;
      end
      if (wr_ph[k] != ep) badph++;
      if (wr_ip[k] != (ep == 3'd3)) badip++;
      if (!wr_noc[k]) badnoc++;
    end
    check(bad4 == 0, "R4", {nm, " network write contents"}, bad4, 0);
    check(bad5 == 0, "R5", {nm, " rewiring and IP write contents"}, bad5, 0);
    check(badph == 0, "R5", {nm, " writes in their phases"}, badph, 0);
    check(badip == 0, "R3", {nm, " IP reset state at writes"}, badip, 0);
    check(badnoc == 0, "R2", {nm, " network out of reset at writes"}, badnoc, 0);
    check(viol_out == 0, "R6", {nm, " outstanding writes"}, viol_out, 0);
    check(ncw == cnt, "R7", {nm, " bitstream word count"}, ncw, cnt);
    badw = 0;
    for (int i = 0; i < cnt && i < ncw && i < 64; i++)
      if (cw[i] != memf(base + 16'(i))) badw++;
    check(badw == 0, "R7", {nm, " bitstream word order and data"}, badw, 0);
    check(cw_bad == 0, "R2", {nm, " words sent with IP in reset"}, cw_bad, 0);
    check(viol_hold == 0, "R8", {nm, " held word under backpressure"}, viol_hold, 0);
    check(viol_idle == 0, "R11", {nm, " ports idle outside their phases"}, viol_idle, 0);
    check(ip_rst_n && noc_rst_n, "R3", {nm, " resets released in application"},
          {noc_rst_n, ip_rst_n}, 3);
  endtask

  task automatic t_zero_count();
    t_boot("zero", 16'h0300, 0, 0, 0, 0);
    check(ncw == 0 && mem_acc == 0, "R9", "zero count sends and reads nothing", ncw + mem_acc, 0);
  endtask

  task automatic t_error(input string nm, input int idx);
    int nw_at;
    mm_mode = 0; mem_mode = 0; cfg_mode = 0; err_at = idx;
    bs_base = 16'h0100; bs_count = 12'd3;
    do_reset();
    wait_phase(3'd7, 20000);
    @(negedge clk);
    check(phase == 3'd7, "R10", {nm, " error phase"}, phase, 7);
    check(!ip_rst_n, "R10", {nm, " IP reset low in error"}, ip_rst_n, 0);
    nw_at = nwr;
    repeat (30) @(negedge clk);
    stray_req = stray_req + 1;
    repeat (10) @(negedge clk);
    check(phase == 3'd7, "R10", {nm, " error sticky after stray response"}, phase, 7);
    check(nwr == idx + 1 && nwr == nw_at, "R10", {nm, " no write after error"}, nwr, idx + 1);
    check(!ip_rst_n && noc_rst_n, "R10", {nm, " resets in error"}, {noc_rst_n, ip_rst_n}, 2);
    if (idx < N_NET)
      check(ncw == 0, "R10", {nm, " no bitstream after network error"}, ncw, 0);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_boot("plain", 16'h0200, 5, 0, 0, 0);
        t_boot("third", 16'h0FFE, 9, 1, 1, 1);
        t_boot("sparse", 16'h2000, 4, 1, 0, 2);
        t_zero_count();
        t_error("neterr", 1);
        t_error("iperr", N_NET + 1);
        t_error("lasterr", N_TOT - 1);
      end
      begin
        while (cyc < 150000) @(negedge clk);
        check(1'b0, "R1", "watchdog expired", cyc, 150000);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule